// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects a set of level-sensitive interrupt lines and presents them to up to four processors. Each interrupt ID has a global enable that software switches by writing the ID number to one of two write-only registers, one that sets the enable and one that clears it. No read-modify-write of a bitmap is needed. Shared IDs carry a small routing register that selects which CPUs may see them. The lowest IDs are private: a CPU sees them unless its own per-CPU mask hides them. Masks are also changed by writing an ID number to a set register or a clear register.

Every access on the register bus carries the number of the accessing CPU, so one address window serves all processors. Reading the acknowledge register returns the ID that the accessing CPU should service. The lowest nonzero eligible ID wins. ID 0 stands for that CPU's doorbell line and is returned only when no nonzero ID is eligible. The value 1023 means that nothing is pending. The read has no side effects, because a level source stays pending until its own line drops. Each CPU has an IRQ output that is high whenever its acknowledge value would not be 1023. A control register reports how many interrupt IDs are implemented.

Top module: `lic_top`

## Requirements
- R1: After reset all global enables are off, every per-CPU mask bit is set (masked), every routing register reads 0, every irq_o bit is low and the acknowledge register reads 1023 for every CPU.
- R2: A write to byte address 0x030 with an ID in data bits [9:0] turns that ID's global enable on. A source whose enable is off never becomes eligible.
- R3: A write to byte address 0x034 with an ID in data bits [9:0] turns that ID's global enable off.
- R4: The routing register of ID n sits at byte address 0x100 + 4*n. Bits [NCPU-1:0] are writable and readable, and bit c selects CPU c. Upper bits read 0. A shared ID (n >= NPRIV) is eligible for CPU c only when routing bit c is set.
- R5: A private ID n (1 <= n < NPRIV) is eligible for CPU c when its line is high, its enable is on and mask bit n of CPU c is clear. Routing has no effect on it. A write of n to 0x048 sets that mask bit and a write of n to 0x04C clears it, both for the CPU named on bus_cpu only.
- R6: ID 0 is eligible for CPU c when doorbell_i[c] is high and mask bit 0 of CPU c is clear. It is reported only when no nonzero ID is eligible for that CPU.
- R7: A read of byte address 0x044 returns, in bits [9:0], the lowest nonzero eligible ID for the CPU named on bus_cpu, else 0 per R6, else 1023. Bits [31:10] read 0.
- R8: irq_o[c] is high exactly when the acknowledge value of CPU c differs from 1023.
- R9: A read of byte address 0x000 returns NSRC in bits [11:2]. All other bits read 0.
- R10: Pending state follows the source lines with no latching. When a line drops, its ID is no longer reported and the IRQ output falls.
- R11: Read data appears on bus_rdata in the cycle after the read request, with bus_rvalid high for exactly that cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Number of the CPU making the access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| src_i | input | NSRC | Level interrupt lines; bit n drives ID n, bit 0 unused |
| doorbell_i | input | NCPU | Per-CPU doorbell summary lines, reported as ID 0 |
| irq_o | output | NCPU | Per-CPU interrupt request |

## Verification
The assertions assume that bus_cpu always names an implemented CPU. They also assume that source, doorbell and bus inputs change only between clock edges, so that the acknowledge value and the IRQ level sampled at one edge describe the same state. The bench drives every input on the falling edge and uses only CPU numbers 0 to 3, which keeps it inside these assumptions. It steps the sources through patterns that hit each eligibility path: shared routed, private masked, doorbell alone and all quiet. It then compares acknowledge reads and IRQ levels with values worked out from the requirements.

// File: rtl/lic_pkg.sv
package lic_pkg;
  // Width of an interrupt ID field on the register bus
  localparam int ID_W = 10;
  // Acknowledge value meaning "nothing pending"
  localparam logic [ID_W-1:0] ID_NONE = '1;

  // Byte offsets of the register window
  localparam int OFF_CTRL     = 'h000;
  localparam int OFF_EN_SET   = 'h030;
  localparam int OFF_EN_CLR   = 'h034;
  localparam int OFF_ACK      = 'h044;
  localparam int OFF_MSK_SET  = 'h048;
  localparam int OFF_MSK_CLR  = 'h04C;
  localparam int OFF_ROUTE    = 'h100;

  // Position of the implemented-ID count inside the control word
  localparam int CTRL_CNT_LSB = 2;
endpackage

// File: rtl/lic_regs.sv
// Register state: global enables, per-ID routing bitmaps, per-CPU private masks.
module lic_regs
  import lic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 4,
  parameter int NPRIV  = 8,
  parameter int ADDR_W = 12,
  parameter int CPU_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CPU_W-1:0]               wr_cpu,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  output logic [NSRC-1:0]                en_q,
  output logic [NSRC-1:0][NCPU-1:0]      route_q,
  output logic [NCPU-1:0][NPRIV-1:0]     mask_q
);
  localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(OFF_EN_CLR);
  localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(OFF_MSK_SET);
  localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(OFF_MSK_CLR);

  logic [ID_W-1:0] wr_id;
  logic            do_en_set, do_en_clr, do_msk_set, do_msk_clr;

  assign wr_id      = wr_data[ID_W-1:0];
  assign do_en_set  = wr_en && (wr_addr == A_EN_SET);
  assign do_en_clr  = wr_en && (wr_addr == A_EN_CLR);
  assign do_msk_set = wr_en && (wr_addr == A_MSK_SET);
  assign do_msk_clr = wr_en && (wr_addr == A_MSK_CLR);

  // R2 / R3 / R4: one enable flop and one routing field per ID
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam logic [ID_W-1:0]   MY_ID = ID_W'(s);
    localparam logic [ADDR_W-1:0] MY_RA = ADDR_W'(OFF_ROUTE + 4 * s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[s] <= 1'b0;
      end else if (do_en_set && wr_id == MY_ID) begin
        en_q[s] <= 1'b1;
      end else if (do_en_clr && wr_id == MY_ID) begin
        en_q[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        route_q[s] <= '0;
      end else if (wr_en && wr_addr == MY_RA) begin
        route_q[s] <= wr_data[NCPU-1:0];
      end
    end
  end

  // R5 / R6: private mask bits, written only for the accessing CPU
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic [CPU_W-1:0] MY_CPU = CPU_W'(c);
    for (genvar p = 0; p < NPRIV; p++) begin : g_priv
      localparam logic [ID_W-1:0] MY_ID = ID_W'(p);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_q[c][p] <= 1'b1;
        end else if (wr_cpu == MY_CPU && wr_id == MY_ID) begin
          if (do_msk_set) begin
            mask_q[c][p] <= 1'b1;
          end else if (do_msk_clr) begin
            mask_q[c][p] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lic_select.sv
// Per-CPU eligibility and lowest-nonzero-ID selection.
module lic_select
  import lic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NPRIV = 8
) (
  input  logic [NSRC-1:0]  src,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  route_col,
  input  logic [NPRIV-1:0] mask,
  input  logic             doorbell,
  output logic [ID_W-1:0]  id,
  output logic             pend
);
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    if (s == 0) begin : g_zero
      // ID 0 belongs to the doorbell, the line at index 0 is unused
      assign elig[s] = 1'b0;
    end else if (s < NPRIV) begin : g_priv
      // R5: private, gated by this CPU's mask, routing ignored
      assign elig[s] = src[s] && en[s] && !mask[s];
    end else begin : g_shared
      // R4: shared, gated by this CPU's routing bit
      assign elig[s] = src[s] && en[s] && route_col[s];
    end
  end

  // R6 / R7: the doorbell is the fallback, the lowest nonzero eligible ID wins
  always_comb begin
    id = ID_NONE;
    if (doorbell && !mask[0]) begin
      id = '0;
    end
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (elig[s]) begin
        id = ID_W'(s);
      end
    end
  end

  // R8: request whenever the acknowledge value is not the idle code
  assign pend = (id != ID_NONE);
endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 4,
  parameter int NPRIV  = 8,
  parameter int ADDR_W = 12,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NCPU-1:0]   doorbell_i,
  output logic [NCPU-1:0]   irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);
  localparam logic [31:0]       CTRL_WORD = 32'(NSRC) << CTRL_CNT_LSB;

  logic                         wr_en, rd_en;
  logic [NSRC-1:0]              en_q;
  logic [NSRC-1:0][NCPU-1:0]    route_q;
  logic [NCPU-1:0][NPRIV-1:0]   mask_q;
  logic [NCPU-1:0][NSRC-1:0]    route_col;
  logic [NCPU-1:0][ID_W-1:0]    ack_id;
  logic [ID_W-1:0]              ack_sel;
  logic [31:0]                  rd_word;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  lic_regs #(
    .NSRC   (NSRC),
    .NCPU   (NCPU),
    .NPRIV  (NPRIV),
    .ADDR_W (ADDR_W),
    .CPU_W  (CPU_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_cpu  (bus_cpu),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .en_q    (en_q),
    .route_q (route_q),
    .mask_q  (mask_q)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSRC; s++) begin : g_col
      assign route_col[c][s] = route_q[s][c];
    end

    lic_select #(
      .NSRC  (NSRC),
      .NPRIV (NPRIV)
    ) u_sel (
      .src       (src_i),
      .en        (en_q),
      .route_col (route_col[c]),
      .mask      (mask_q[c]),
      .doorbell  (doorbell_i[c]),
      .id        (ack_id[c]),
      .pend      (irq_o[c])
    );
  end

  // Acknowledge value for the CPU making the access
  always_comb begin
    ack_sel = ID_NONE;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_cpu == CPU_W'(c)) begin
        ack_sel = ack_id[c];
      end
    end
  end

  // R7 / R9 / R4 / R11: read decode, unmapped addresses give zero
  always_comb begin
    rd_word = '0;
    if (bus_addr == A_CTRL) begin
      rd_word = CTRL_WORD;
    end else if (bus_addr == A_ACK) begin
      rd_word = 32'(ack_sel);
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        if (bus_addr == ADDR_W'(OFF_ROUTE + 4 * s)) begin
          rd_word = 32'(route_q[s]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) begin
        bus_rdata <= rd_word;
      end
    end
  end
endmodule

// File: rtl/lic_chk.sv
module lic_chk
  import lic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12,
  parameter int CPU_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [NSRC-1:0]   src_i,
  input logic [NCPU-1:0]   doorbell_i,
  input logic [NCPU-1:0]   irq_o
);
  logic rd_req, ack_rd, ctrl_rd, sel_irq;

  assign rd_req  = bus_valid && !bus_write;
  assign ack_rd  = rd_req && (bus_addr == ADDR_W'(OFF_ACK));
  assign ctrl_rd = rd_req && (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_irq = irq_o[bus_cpu];

  // R11: read data strobe follows each read by one cycle
  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  // R11: no strobe without a read
  a_r11_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  // R7: acknowledge value is an implemented ID or the idle code
  a_r7_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> (bus_rdata[31:ID_W] == '0 &&
                (32'(bus_rdata[ID_W-1:0]) < NSRC || bus_rdata[ID_W-1:0] == ID_NONE)));

  // R8: IRQ level agrees with the acknowledge value seen on the same edge
  a_r8_irq_vs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ((bus_rdata[ID_W-1:0] != ID_NONE) == $past(sel_irq)));

  // R9: control word reports the implemented ID count
  a_r9_ctrl_count: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (bus_rdata == (32'(NSRC) << CTRL_CNT_LSB)));

  // R10: with every line low no CPU is interrupted
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[NSRC-1:1] == '0 && doorbell_i == '0) |-> (irq_o == '0));
endmodule

bind lic_top lic_chk #(
  .NSRC   (NSRC),
  .NCPU   (NCPU),
  .ADDR_W (ADDR_W),
  .CPU_W  (CPU_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .src_i      (src_i),
  .doorbell_i (doorbell_i),
  .irq_o      (irq_o)
);

// File: tb/lic_top_tb.sv
`timescale 1ns/1ps
module lic_top_tb;
  localparam int NSRC = 32;
  localparam int NCPU = 4;

  typedef enum logic [2:0] {OP_WR, OP_RD, OP_SRC, OP_DB, OP_IRQ} op_t;
  typedef struct packed {
    op_t         op;
    logic [1:0]  cpu;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  function automatic vec_t mk(op_t op, int cpu, int req, int addr, int data, int exp);
    mk = '{op, 2'(cpu), 4'(req), 12'(addr), 32'(data), 32'(exp)};
  endfunction

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    mk(OP_RD, 0, 9, 'h000, 0, 'h80),          // R9 count field
    mk(OP_RD, 0, 1, 'h044, 0, 'h3FF),         // R1 idle ack
    mk(OP_IRQ, 0, 1, 0, 0, 0),                // R1 irq low
    mk(OP_SRC, 0, 0, 0, 'h00000400, 0),
    mk(OP_RD, 0, 2, 'h044, 0, 'h3FF),         // R2 disabled source unseen
    mk(OP_WR, 0, 0, 'h030, 10, 0),
    mk(OP_RD, 1, 4, 'h044, 0, 'h3FF),         // R4 not routed yet
    mk(OP_WR, 0, 0, 'h128, 2, 0),
    mk(OP_RD, 0, 4, 'h128, 0, 2),             // R4 route readback
    mk(OP_RD, 1, 7, 'h044, 0, 10),            // R7 routed ID
    mk(OP_RD, 0, 4, 'h044, 0, 'h3FF),         // R4 other CPU blocked
    mk(OP_IRQ, 0, 8, 0, 0, 'h2),              // R8
    mk(OP_SRC, 0, 0, 0, 'h00100400, 0),
    mk(OP_WR, 0, 0, 'h030, 20, 0),
    mk(OP_WR, 0, 0, 'h150, -1, 0),
    mk(OP_RD, 0, 4, 'h150, 0, 'hF),           // R4 upper bits zero
    mk(OP_RD, 1, 7, 'h044, 0, 10),            // R7 lowest wins
    mk(OP_RD, 2, 7, 'h044, 0, 20),            // R7
    mk(OP_WR, 0, 0, 'h034, 10, 0),
    mk(OP_RD, 1, 3, 'h044, 0, 20),            // R3 disabled
    mk(OP_SRC, 0, 0, 0, 'h00100408, 0),
    mk(OP_WR, 0, 0, 'h030, 3, 0),
    mk(OP_RD, 0, 5, 'h044, 0, 20),            // R5 private masked
    mk(OP_WR, 0, 0, 'h04C, 3, 0),
    mk(OP_RD, 0, 5, 'h044, 0, 3),             // R5 unmasked on CPU0
    mk(OP_RD, 3, 5, 'h044, 0, 20),            // R5 CPU3 still masked
    mk(OP_WR, 0, 0, 'h048, 3, 0),
    mk(OP_RD, 0, 5, 'h044, 0, 20),            // R5 re-masked
    mk(OP_DB, 0, 0, 0, 'h4, 0),
    mk(OP_SRC, 0, 0, 0, 0, 0),
    mk(OP_RD, 2, 6, 'h044, 0, 'h3FF),         // R6 doorbell masked
    mk(OP_WR, 2, 0, 'h04C, 0, 0),
    mk(OP_RD, 2, 6, 'h044, 0, 0),             // R6 doorbell reported
    mk(OP_IRQ, 0, 8, 0, 0, 'h4),              // R8
    mk(OP_SRC, 0, 0, 0, 'h00100000, 0),
    mk(OP_RD, 2, 6, 'h044, 0, 20),            // R6 nonzero ID first
    mk(OP_SRC, 0, 0, 0, 0, 0),
    mk(OP_DB, 0, 0, 0, 0, 0),
    mk(OP_RD, 3, 10, 'h044, 0, 'h3FF),        // R10 line dropped
    mk(OP_IRQ, 0, 10, 0, 0, 0),               // R10
    mk(OP_RD, 0, 11, 'h020, 0, 0)             // R11 unmapped
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [1:0]      bus_cpu = '0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NSRC-1:0] src_i = '0;
  logic [NCPU-1:0] doorbell_i = '0;
  logic [NCPU-1:0] irq_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  lic_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_cpu    (bus_cpu),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .src_i      (src_i),
    .doorbell_i (doorbell_i),
    .irq_o      (irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int cpu, int addr, logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(int cpu, int addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    data = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
      case (VEC[i].op)
        OP_WR:  bus_wr(VEC[i].cpu, VEC[i].addr, VEC[i].data);
        OP_RD: begin
          bus_rd(VEC[i].cpu, VEC[i].addr, rd);
          check(tag, rd, VEC[i].exp);
        end
        OP_SRC: begin @(negedge clk); src_i = VEC[i].data[NSRC-1:0]; end
        OP_DB:  begin @(negedge clk); doorbell_i = VEC[i].data[NCPU-1:0]; end
        default: begin @(negedge clk); check(tag, 32'(irq_o), VEC[i].exp); end
      endcase
    end

    // R11: strobe lasts exactly one cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h000;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R11 rvalid high", 32'(bus_rvalid), 32'd1);
    @(negedge clk);
    check("R11 rvalid low", 32'(bus_rvalid), 32'd0);

    // R1: reset mid-run with every line active
    @(negedge clk);
    src_i = '1; doorbell_i = '1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", 32'(irq_o), 32'd0);
    bus_rd(1, 'h044, rd);
    check("R1 ack after reset", rd, 32'h3FF);
    bus_rd(0, 'h150, rd);
    check("R1 route after reset", rd, 32'h0);

    // R5: private ID ignores routing, reaches every unmasked CPU
    bus_wr(0, 'h030, 5);
    bus_wr(3, 'h04C, 5);
    bus_rd(3, 'h044, rd);
    check("R5 private on CPU3", rd, 32'd5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule